// File: doc/BRIEF.md
# Binary Trie Longest Prefix Lookup

This block resolves a 32-bit IPv4 destination address to an output port by longest prefix match. It holds a small binary trie in on-chip registers. Each node has a pointer for the 0 branch, a pointer for the 1 branch, a flag that marks the node as the end of a stored prefix, and a 4-bit port. Node 0 is the root, and a pointer value of 0 means that no child exists.

A lookup starts from the root and consumes one address bit per clock, beginning at the most significant bit. While it descends, the engine remembers the port of the deepest prefix-marked node it has reached. The walk stops when the next child pointer is null or when all 32 bits have been used. A single-cycle done pulse then carries the port and a hit flag. If no node on the path was marked, the engine reports a miss together with a configurable default port.

Routing software fills the trie through a node write port while the engine is idle. Only one lookup is in flight at a time, and the busy output shows when that is the case.

Top module: `trie_lpm`

## Requirements
- R1: After reset, done_o, busy_o and hit_o are low and every node is cleared, so any lookup misses after one walk step.
- R2: A request is accepted only on a clock edge where req_valid_i is high and busy_o is low. busy_o stays high from the accepting edge until the edge that raises done_o. A request that arrives while busy_o is high is ignored.
- R3: The walk begins at node 0 and takes address bits from bit 31 downward. A 0 bit follows the left pointer and a 1 bit follows the right pointer. A zero pointer ends the walk, and the walk never goes deeper than 32 bits.
- R4: When several stored prefixes match, port_o is the port of the longest one and hit_o is 1. This holds for nested prefixes such as /16 inside /24 and /24 inside /32.
- R5: When no node on the walked path is marked as a prefix, hit_o is 0 and port_o equals DEFAULT_PORT (default 15).
- R6: done_o is a one-cycle pulse. It rises exactly k clock edges after the accepting edge, where k is the number of nodes visited, root included, up to 33.
- R7: A node write (wr_en_i) is dropped while busy_o is high. When the engine is idle, a node write takes effect for the next lookup.
- R8: port_o and hit_o change only on the edge that raises done_o and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Node write strobe |
| wr_idx_i | input | 7 | Index of the node to write |
| wr_left_i | input | 7 | Child pointer for a 0 bit (0 = none) |
| wr_right_i | input | 7 | Child pointer for a 1 bit (0 = none) |
| wr_pfx_i | input | 1 | Node ends a stored prefix |
| wr_port_i | input | 4 | Port bound to that prefix |
| req_valid_i | input | 1 | Lookup request |
| req_addr_i | input | 32 | Destination address |
| busy_o | output | 1 | Lookup in progress |
| done_o | output | 1 | Result valid pulse |
| hit_o | output | 1 | A prefix matched |
| port_o | output | 4 | Resolved port, or the default port on a miss |

## Verification
The hardest case to reach is a node write or a second request that lands in the middle of a walk. The bench starts a four-step lookup and, in the cycle after the accepting edge, rewrites the exact node that the walk will reach. It then checks both the finishing result and a fresh lookup, which shows that the write was dropped. The full 33-node walk is reached by installing a /32 host route under a /24, which makes the depth limit and the latency bound observable.

// File: rtl/trie_lpm_pkg.sv
package trie_lpm_pkg;
  typedef enum logic {ST_IDLE, ST_WALK} walk_state_e;
endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem #(
  parameter int NODES  = 128,
  parameter int PTR_W  = 7,
  parameter int PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [PTR_W-1:0]  wr_left_i,
  input  logic [PTR_W-1:0]  wr_right_i,
  input  logic              wr_pfx_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [PTR_W-1:0]  rd_left_o,
  output logic [PTR_W-1:0]  rd_right_o,
  output logic              rd_pfx_o,
  output logic [PORT_W-1:0] rd_port_o
);
  logic [PTR_W-1:0]  left_q  [NODES];
  logic [PTR_W-1:0]  right_q [NODES];
  logic [PORT_W-1:0] port_q  [NODES];
  logic [NODES-1:0]  pfx_q;
  logic [NODES-1:0]  we;

  // writes are gated off during a walk
  for (genvar g = 0; g < NODES; g++) begin : g_we
    assign we[g] = wr_en_i && !busy_i && (wr_idx_i == PTR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NODES; i++) begin
        left_q[i]  <= '0;
        right_q[i] <= '0;
        port_q[i]  <= '0;
      end
      pfx_q <= '0;
    end else begin
      for (int i = 0; i < NODES; i++) begin
        if (we[i]) begin
          left_q[i]  <= wr_left_i;
          right_q[i] <= wr_right_i;
          port_q[i]  <= wr_port_i;
          pfx_q[i]   <= wr_pfx_i;
        end
      end
    end
  end

  assign rd_left_o  = left_q[rd_idx_i];
  assign rd_right_o = right_q[rd_idx_i];
  assign rd_pfx_o   = pfx_q[rd_idx_i];
  assign rd_port_o  = port_q[rd_idx_i];
endmodule

// File: rtl/trie_walker.sv
module trie_walker
  import trie_lpm_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int PTR_W        = 7,
  parameter int PORT_W       = 4,
  parameter int DEFAULT_PORT = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [PTR_W-1:0]  rd_idx_o,
  input  logic [PTR_W-1:0]  rd_left_i,
  input  logic [PTR_W-1:0]  rd_right_i,
  input  logic              rd_pfx_i,
  input  logic [PORT_W-1:0] rd_port_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [PORT_W-1:0] DEF_P = PORT_W'(DEFAULT_PORT);

  walk_state_e       state_q;
  logic [PTR_W-1:0]  cur_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              best_hit_q;
  logic [PORT_W-1:0] best_port_q;

  logic              hit_now;
  logic [PORT_W-1:0] port_now;
  logic [PTR_W-1:0]  nxt;
  logic              stop;

  assign rd_idx_o = cur_q;
  assign hit_now  = best_hit_q | rd_pfx_i;
  assign port_now = rd_pfx_i ? rd_port_i : best_port_q;
  assign nxt      = addr_q[ADDR_W-1] ? rd_right_i : rd_left_i;
  assign stop     = (cnt_q == CNT_W'(ADDR_W)) || (nxt == '0);
  assign busy_o   = (state_q == ST_WALK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
      best_hit_q  <= 1'b0;
      best_port_q <= '0;
      done_o      <= 1'b0;
      hit_o       <= 1'b0;
      port_o      <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q     <= ST_WALK;
            cur_q       <= '0;
            addr_q      <= req_addr_i;
            cnt_q       <= '0;
            best_hit_q  <= 1'b0;
            best_port_q <= '0;
          end
        end
        ST_WALK: begin
          if (stop) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            hit_o   <= hit_now;
            port_o  <= hit_now ? port_now : DEF_P;
          end else begin
            cur_q       <= nxt;
            addr_q      <= addr_q << 1;
            cnt_q       <= cnt_q + 1'b1;
            best_hit_q  <= hit_now;
            best_port_q <= port_now;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  // R3
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= CNT_W'(ADDR_W)));
  // R5
  miss_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (port_o == DEF_P));
endmodule

// File: rtl/trie_lpm.sv
module trie_lpm #(
  parameter int ADDR_W       = 32,
  parameter int PORT_W       = 4,
  parameter int NODES        = 128,
  parameter int DEFAULT_PORT = 15,
  localparam int PTR_W       = $clog2(NODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [PTR_W-1:0]  wr_left_i,
  input  logic [PTR_W-1:0]  wr_right_i,
  input  logic              wr_pfx_i,
  input  logic [PORT_W-1:0] wr_port_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              hit_o,
  output logic [PORT_W-1:0] port_o
);
  logic [PTR_W-1:0]  rd_idx, rd_left, rd_right;
  logic              rd_pfx;
  logic [PORT_W-1:0] rd_port;

  trie_node_mem #(.NODES(NODES), .PTR_W(PTR_W), .PORT_W(PORT_W)) u_mem (
    .clk_i, .rst_ni,
    .busy_i    (busy_o),
    .wr_en_i, .wr_idx_i, .wr_left_i, .wr_right_i, .wr_pfx_i, .wr_port_i,
    .rd_idx_i  (rd_idx),
    .rd_left_o (rd_left),
    .rd_right_o(rd_right),
    .rd_pfx_o  (rd_pfx),
    .rd_port_o (rd_port)
  );

  trie_walker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .PORT_W(PORT_W),
                .DEFAULT_PORT(DEFAULT_PORT)) u_walk (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i,
    .rd_idx_o  (rd_idx),
    .rd_left_i (rd_left),
    .rd_right_i(rd_right),
    .rd_pfx_i  (rd_pfx),
    .rd_port_i (rd_port),
    .busy_o, .done_o, .hit_o, .port_o
  );

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(port_o) && $stable(hit_o)));
endmodule

// File: tb/trie_lpm_tb.sv
module trie_lpm_tb;
  localparam int NODES = 128;
  localparam int PTR_W = 7;
  localparam int DEF_P = 15;

  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_pfx = 0, req_valid = 0;
  logic [6:0]  wr_idx = 0, wr_left = 0, wr_right = 0;
  logic [3:0]  wr_port = 0;
  logic [31:0] req_addr = 0;
  logic        busy, done, hit;
  logic [3:0]  port;

  int checks = 0, fails = 0;

  // bench shadow of the node table, used only to build it
  logic [6:0] sh_l [NODES];
  logic [6:0] sh_r [NODES];
  logic       sh_v [NODES];
  logic [3:0] sh_p [NODES];
  int next_free = 1;

  // reference prefix list
  logic [31:0] rf_val [16];
  int          rf_len [16];
  int          rf_port[16];
  int          rf_n = 0;

  always #2.5 clk = ~clk;

  trie_lpm u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_left_i(wr_left), .wr_right_i(wr_right),
    .wr_pfx_i(wr_pfx), .wr_port_i(wr_port),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .busy_o(busy), .done_o(done), .hit_o(hit), .port_o(port)
  );

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_lpm(input logic [31:0] a);
    int best_len = -1, best_port = -1;
    for (int i = 0; i < rf_n; i++) begin
      logic match;
      match = (rf_len[i] == 0) || ((a >> (32 - rf_len[i])) == (rf_val[i] >> (32 - rf_len[i])));
      if (match && rf_len[i] > best_len) begin
        best_len  = rf_len[i];
        best_port = rf_port[i];
      end
    end
    return best_port;
  endfunction

  task automatic wr_node(input int idx);
    @(negedge clk);
    wr_en = 1; wr_idx = 7'(idx); wr_left = sh_l[idx]; wr_right = sh_r[idx];
    wr_pfx = sh_v[idx]; wr_port = sh_p[idx];
    @(negedge clk);
    wr_en = 0;
  endtask

  // prefix is left-aligned in val
  task automatic add_prefix(input logic [31:0] val, input int len, input int p, output int leaf);
    int cur = 0;
    for (int i = 0; i < len; i++) begin
      logic b;
      int c;
      b = val[31-i];
      c = b ? int'(sh_r[cur]) : int'(sh_l[cur]);
      if (c == 0) begin
        c = next_free++;
        if (b) sh_r[cur] = 7'(c); else sh_l[cur] = 7'(c);
        wr_node(cur);
      end
      cur = c;
    end
    sh_v[cur] = 1; sh_p[cur] = 4'(p);
    wr_node(cur);
    rf_val[rf_n] = val; rf_len[rf_n] = len; rf_port[rf_n] = p; rf_n++;
    leaf = cur;
  endtask

  task automatic lookup(input logic [31:0] a, output logic h, output logic [3:0] p, output int cyc);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    while (!done && cyc < 100) begin
      @(posedge clk); #1;
      if (!done) cyc++;
    end
    h = hit; p = port;
  endtask

  task automatic check_lpm(input string req, input logic [31:0] a);
    logic h; logic [3:0] p; int cyc, r;
    lookup(a, h, p, cyc);
    r = ref_lpm(a);
    chk({req, " hit"}, 32'(h), 32'(r >= 0));
    chk({req, " port"}, 32'(p), (r >= 0) ? 32'(r) : 32'(DEF_P));
  endtask

  task automatic t_reset;
    logic h; logic [3:0] p; int cyc;
    #1;
    chk("R1 done", 32'(done), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 hit", 32'(hit), 0);
    lookup(32'hC0A8_0001, h, p, cyc);
    chk("R1 empty table hit", 32'(h), 0);
    chk("R5 miss default port", 32'(p), DEF_P);
    chk("R6 root-only latency", 32'(cyc), 1);
  endtask

  int leaf001, leaf_host;

  task automatic t_small_table;
    int tmp;
    logic h; logic [3:0] p; int cyc;
    add_prefix(32'h2000_0000, 3, 2, leaf001);
    add_prefix(32'h4000_0000, 4, 3, tmp);
    add_prefix(32'h8000_0000, 2, 1, tmp);
    add_prefix(32'hB000_0000, 6, 5, tmp);
    check_lpm("R3 path 001", 32'h2000_0000);
    check_lpm("R3 path 0100", 32'h4000_0000);
    check_lpm("R5 path 0101 miss", 32'h5000_0000);
    check_lpm("R4 path 101100", 32'hB000_0000);
    check_lpm("R4 path 101101 falls back to 10", 32'hB400_0000);
    check_lpm("R5 path 11 miss", 32'hC000_0000);
    lookup(32'hB000_0000, h, p, cyc);
    chk("R6 seven-node latency", 32'(cyc), 7);
  endtask

  task automatic t_nested;
    int tmp;
    add_prefix(32'h0C52_0000, 16, 3, tmp);
    add_prefix(32'h0C52_6400, 24, 2, tmp);
    check_lpm("R4 12.82.100.101 takes /24", 32'h0C52_6465);
    check_lpm("R4 12.82.7.1 takes /16", 32'h0C52_0701);
    check_lpm("R5 12.83.0.0 miss", 32'h0C53_0000);
  endtask

  task automatic t_host;
    int tmp;
    logic h; logic [3:0] p; int cyc;
    add_prefix(32'h8010_7800, 24, 4, tmp);
    add_prefix(32'h8010_786F, 32, 6, leaf_host);
    check_lpm("R4 host route /32", 32'h8010_786F);
    check_lpm("R4 sibling of host takes /24", 32'h8010_7870);
    lookup(32'h8010_786F, h, p, cyc);
    chk("R6 full-depth latency", 32'(cyc), 33);
    chk("R3 full-depth port", 32'(p), 6);
  endtask

  task automatic t_busy_req;
    int dones = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 32'hB000_0000;
    @(posedge clk);
    @(negedge clk);
    req_addr = 32'h2000_0000;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk("R2 busy during walk", 32'(busy), 1);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      if (done) begin
        dones++;
        chk("R2 first request result", 32'(port), 5);
      end
    end
    chk("R2 second request ignored", 32'(dones), 1);
    chk("R2 idle after done", 32'(busy), 0);
    chk("R8 result held", 32'(port), 5);
  endtask

  task automatic t_busy_write;
    logic h; logic [3:0] p; int cyc;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h2000_0000;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    wr_en = 1; wr_idx = 7'(leaf001); wr_left = 0; wr_right = 0; wr_pfx = 1; wr_port = 9;
    @(negedge clk);
    wr_en = 0;
    while (!done) begin @(posedge clk); #1; end
    chk("R7 walk unaffected", 32'(port), 2);
    lookup(32'h2000_0000, h, p, cyc);
    chk("R7 busy write dropped", 32'(p), 2);
    sh_p[leaf001] = 9;
    wr_node(leaf001);
    lookup(32'h2000_0000, h, p, cyc);
    chk("R7 idle write applied", 32'(p), 9);
    sh_p[leaf001] = 2;
    wr_node(leaf001);
  endtask

  initial begin
    for (int i = 0; i < NODES; i++) begin
      sh_l[i] = 0; sh_r[i] = 0; sh_v[i] = 0; sh_p[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_small_table();
    t_nested();
    t_host();
    t_busy_req();
    t_busy_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule